// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit timer for a peripheral bus. Its count rate comes from the system clock. The clock first passes through an optional divide-by-16 stage and then through a programmable divide-by-(N+1) prescaler. Each time the counter steps onto the value held in the reference register, the block sets a sticky reference flag. When the interrupt enable is set, that flag drives an interrupt line. The counter can either fall back to zero after a match or keep running and wrap.

Software controls the timer through five byte-offset locations: a mode word, the reference value, a capture holding register, the live counter and an event register. Bits are cleared from the event register by writing ones to them. Writing the mode word or the reference value restarts the count from zero with the new settings. Turning the run bit off also clears the reference value. Input capture and the output pin are not part of this block. Their mode bits and the capture register are only stored and read back.

Top module: `refcmp_timer`

## Requirements
- R1: After reset every register location reads zero and `irq` is low.
- R2: Byte offsets: 0x00 mode, 0x04 reference, 0x08 capture, 0x0C counter, 0x11 event (bits 1:0). The capture register reads back what was last written. Any other offset reads zero, and writes to it change nothing.
- R3: Mode word fields: bit 0 run, bits 2:1 clock source, bit 3 restart-on-match, bit 4 interrupt enable, bits 15:8 prescale value P. Bits 7:5 are stored and read back only.
- R4: With clock source 1, the counter advances once every P+1 system clocks. The first advance lands P+1 clocks after the mode write.
- R5: With clock source 2, the counter advances once every 16*(P+1) system clocks.
- R6: The counter holds its value when the run bit is clear or the clock source is 0 or 3.
- R7: A write to the mode or reference location sets the counter and both divider stages to zero.
- R8: A write to the counter location loads the counter with the written value, and the load takes priority over a count step in the same clock.
- R9: The reference event (event bit 1) is set in the clock where the counter steps onto the reference value.
- R10: With restart-on-match set, a counter equal to the reference returns to zero on its next step. Otherwise it counts on and wraps from 0xFFFF to 0.
- R11: A write to the event location clears exactly the event bits written as one. The capture event (bit 0) is never set by the block.
- R12: `irq` is high exactly when the interrupt enable bit and the reference event bit are both set. It follows register writes in the next clock.
- R13: A mode write that takes the run bit from one to zero clears the reference register, and the mode word takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Reference-match interrupt |

## Verification
The hardest state to reach from the ports is a counter near 0xFFFF in free-running mode. Counting there at the fastest rate would take 65,536 clocks. The bench gets there by writing 0xFFFE straight into the counter and then watching it wrap to zero and match a reference of one. The divide-by-16 path is also slow to observe. It is reached by sampling exactly one clock before and one clock at each expected step, so that an off-by-one in either divider stage shows up.

// File: rtl/refcmp_timer_pkg.sv
package refcmp_timer_pkg;

   localparam int unsigned ADDR_W = 5;

   localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_REF  = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_CAPT = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h11;

   // clock source selector values
   typedef enum logic [1:0] {
      SRC_OFF0 = 2'd0,
      SRC_SYS  = 2'd1,
      SRC_SLOW = 2'd2,
      SRC_OFF3 = 2'd3
   } clk_src_e;

   // bit positions inside the mode word
   localparam int unsigned MB_RUN     = 0;
   localparam int unsigned MB_SRC_LO  = 1;
   localparam int unsigned MB_RESTART = 3;
   localparam int unsigned MB_IRQ_EN  = 4;
   localparam int unsigned MB_PRE_LO  = 8;

   // event register bits
   localparam int unsigned EB_CAPT = 0;
   localparam int unsigned EB_REF  = 1;

endpackage

// File: rtl/refcmp_tick_gen.sv
module refcmp_tick_gen #(
   parameter int unsigned PRE_W    = 8,
   parameter int unsigned SLOW_DIV = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic             slow_sel,
   input  logic [PRE_W-1:0] pre_val,
   output logic             tick
);

   logic             slow_done;
   logic [PRE_W-1:0] pre_q;
   logic             pre_done;

   generate
      if (SLOW_DIV > 1) begin : g_slow
         localparam int unsigned SW = $clog2(SLOW_DIV);
         localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
         logic [SW-1:0] slow_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               slow_q <= '0;
            end else if (run && slow_sel) begin
               if (slow_q == SLOW_LAST) slow_q <= '0;
               else                     slow_q <= slow_q + 1'b1;
            end
         end

         assign slow_done = !slow_sel || (slow_q == SLOW_LAST);
      end else begin : g_noslow
         assign slow_done = 1'b1;
      end
   endgenerate

   assign pre_done = (pre_q == pre_val);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         pre_q <= '0;
      end else if (run && slow_done) begin
         if (pre_done) pre_q <= '0;
         else          pre_q <= pre_q + 1'b1;
      end
   end

   assign tick = run && !clear && slow_done && pre_done;

endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             restart_mode,
   input  logic [CNT_W-1:0] ref_val,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_step;
   logic             at_ref;

   assign at_ref   = (cnt_q == ref_val);
   assign cnt_step = (restart_mode && at_ref) ? '0 : cnt_q + 1'b1;

   // clear wins over load, load wins over a step
   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt_q <= '0;
      else if (load)       cnt_q <= load_val;
      else if (tick)       cnt_q <= cnt_step;
   end

   assign hit = tick && !clear && !load && (cnt_step == ref_val);
   assign cnt = cnt_q;

endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
   import refcmp_timer_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRE_W    = 8,
   parameter int unsigned SLOW_DIV = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              irq
);

   localparam int unsigned DATA_W = 16;
   localparam int unsigned MODE_W = MB_PRE_LO + PRE_W;

   generate
      if (MODE_W > DATA_W) begin : g_bad_mode
         $error("refcmp_timer: prescale field does not fit the data bus");
      end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("refcmp_timer: CNT_W must be between 2 and 16");
      end
      if (SLOW_DIV == 0) begin : g_bad_slow
         $error("refcmp_timer: SLOW_DIV must be at least 1");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  ref_q;
   logic [DATA_W-1:0] capt_q;
   logic [1:0]        evt_q;

   logic              wr_mode, wr_ref, wr_capt, wr_cnt, wr_evt;
   logic              restart_pulse;
   logic              run_ok;
   logic              tick;
   logic              hit;
   logic [CNT_W-1:0]  cnt_q;
   logic [1:0]        evt_clr;
   clk_src_e          src;

   assign wr_mode = bus_we && (bus_addr == OFS_MODE);
   assign wr_ref  = bus_we && (bus_addr == OFS_REF);
   assign wr_capt = bus_we && (bus_addr == OFS_CAPT);
   assign wr_cnt  = bus_we && (bus_addr == OFS_CNT);
   assign wr_evt  = bus_we && (bus_addr == OFS_EVT);

   assign restart_pulse = wr_mode || wr_ref;

   assign src    = clk_src_e'(mode_q[MB_SRC_LO +: 2]);
   assign run_ok = mode_q[MB_RUN] && ((src == SRC_SYS) || (src == SRC_SLOW));

   // mode and reference registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         ref_q  <= '0;
      end else begin
         if (wr_mode) begin
            mode_q <= bus_wdata[MODE_W-1:0];
            if (mode_q[MB_RUN] && !bus_wdata[MB_RUN]) ref_q <= '0;
         end
         if (wr_ref) ref_q <= bus_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       capt_q <= '0;
      else if (wr_capt) capt_q <= bus_wdata;
   end

   // event flags: write-one-to-clear, a new match wins over a clear
   assign evt_clr = wr_evt ? bus_wdata[1:0] : 2'b00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q <= '0;
      end else begin
         evt_q[EB_CAPT] <= evt_q[EB_CAPT] && !evt_clr[EB_CAPT];
         evt_q[EB_REF]  <= hit || (evt_q[EB_REF] && !evt_clr[EB_REF]);
      end
   end

   refcmp_tick_gen #(
      .PRE_W    (PRE_W),
      .SLOW_DIV (SLOW_DIV)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (restart_pulse),
      .run      (run_ok),
      .slow_sel (src == SRC_SLOW),
      .pre_val  (mode_q[MB_PRE_LO +: PRE_W]),
      .tick     (tick)
   );

   refcmp_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear        (restart_pulse),
      .load         (wr_cnt),
      .load_val     (bus_wdata[CNT_W-1:0]),
      .tick         (tick),
      .restart_mode (mode_q[MB_RESTART]),
      .ref_val      (ref_q),
      .cnt          (cnt_q),
      .hit          (hit)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_MODE: bus_rdata = DATA_W'(mode_q);
         OFS_REF:  bus_rdata = DATA_W'(ref_q);
         OFS_CAPT: bus_rdata = capt_q;
         OFS_CNT:  bus_rdata = DATA_W'(cnt_q);
         OFS_EVT:  bus_rdata = DATA_W'(evt_q);
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = mode_q[MB_IRQ_EN] && evt_q[EB_REF];

endmodule

// File: rtl/refcmp_timer_chk.sv
module refcmp_timer_chk
   import refcmp_timer_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned MODE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [15:0]       bus_wdata,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  ref_v,
   input logic [MODE_W-1:0] mode,
   input logic [1:0]        evt
);

   AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[MB_RUN] && !bus_we) |=> $stable(cnt)); // R6

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_we) && (cnt != $past(cnt))) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0))); // R10

   AST_EVT_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt[EB_REF]) |-> (cnt == ref_v)); // R9

   AST_EVT_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(evt[EB_REF]) |-> ($past(bus_we) && ($past(bus_addr) == OFS_EVT) && $past(bus_wdata[EB_REF]))); // R11

   AST_DISABLE_CLEARS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == OFS_MODE) && mode[MB_RUN] && !bus_wdata[MB_RUN]) |=> (ref_v == '0)); // R13

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($rose(evt[EB_REF]) || $past(bus_we))); // R12

endmodule

bind refcmp_timer refcmp_timer_chk #(
   .CNT_W  (CNT_W),
   .MODE_W (MODE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .cnt       (cnt_q),
   .ref_v     (ref_q),
   .mode      (mode_q),
   .evt       (evt_q)
);

// File: tb/test_refcmp_timer.sv
module test_refcmp_timer;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_we;
   logic [4:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refcmp_timer i_refcmp_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAPT = 5'h08,
                          A_CNT = 5'h0C, A_EVT = 5'h11;

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%04h expected=0x%04h", tag, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic expect_reg(input string tag, input logic [4:0] a, input logic [15:0] exp);
      logic [15:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   // stop, clear reference and flags
   task automatic quiesce();
      wr(A_MODE, 16'h0001);
      wr(A_MODE, 16'h0000);
      wr(A_EVT, 16'h0003);
   endtask

   task automatic t_reset();
      expect_reg("R1 mode", A_MODE, 16'h0);
      expect_reg("R1 ref", A_REF, 16'h0);
      expect_reg("R1 capt", A_CAPT, 16'h0);
      expect_reg("R1 cnt", A_CNT, 16'h0);
      expect_reg("R1 evt", A_EVT, 16'h0);
      check("R1 irq", {15'd0, irq}, 16'h0);
   endtask

   task automatic t_regs();
      wr(A_CAPT, 16'hBEEF);
      expect_reg("R2 capture readback", A_CAPT, 16'hBEEF);
      wr(A_MODE, 16'h05E0);
      expect_reg("R3 mode readback", A_MODE, 16'h05E0);
      wr(5'h14, 16'hFFFF);
      wr(5'h02, 16'hFFFF);
      expect_reg("R2 undefined read", 5'h14, 16'h0);
      expect_reg("R2 undefined read 0x02", 5'h02, 16'h0);
      expect_reg("R2 mode untouched", A_MODE, 16'h05E0);
      expect_reg("R2 capture untouched", A_CAPT, 16'hBEEF);
      expect_reg("R2 evt untouched", A_EVT, 16'h0);
   endtask

   task automatic t_restart_irq();
      quiesce();
      wr(A_REF, 16'd4);
      wr(A_MODE, 16'h001B);                       // run, src 1, restart, irq enable
      cyc(3);
      expect_reg("R4 cnt after 3", A_CNT, 16'd3);
      expect_reg("R9 no event yet", A_EVT, 16'h0);
      check("R12 irq low", {15'd0, irq}, 16'h0);
      cyc(1);
      expect_reg("R9 cnt at ref", A_CNT, 16'd4);
      expect_reg("R9 ref event", A_EVT, 16'h2);
      check("R12 irq high", {15'd0, irq}, 16'h1);
      cyc(1);
      expect_reg("R10 restart to zero", A_CNT, 16'd0);
      wr(A_EVT, 16'h0000);
      expect_reg("R11 zero write keeps", A_EVT, 16'h2);
      wr(A_EVT, 16'h0001);
      expect_reg("R11 capture bit write keeps ref", A_EVT, 16'h2);
      wr(A_EVT, 16'h0002);
      expect_reg("R11 ref event cleared", A_EVT, 16'h0);
      check("R12 irq cleared", {15'd0, irq}, 16'h0);
      expect_reg("R10 count after clear", A_CNT, 16'd3);
      cyc(1);
      check("R12 irq again", {15'd0, irq}, 16'h1);
      wr(A_MODE, 16'h000B);                       // interrupt enable off
      check("R12 irq masked", {15'd0, irq}, 16'h0);
      expect_reg("R12 event kept", A_EVT, 16'h2);
      expect_reg("R7 mode write clears counter", A_CNT, 16'h0);
      wr(A_MODE, 16'h0520);                       // run 1 -> 0
      expect_reg("R13 ref cleared", A_REF, 16'h0);
      expect_reg("R13 mode takes value", A_MODE, 16'h0520);
      cyc(5);
      expect_reg("R6 stopped", A_CNT, 16'h0);
   endtask

   task automatic t_wrap();
      quiesce();
      wr(A_REF, 16'd1);
      wr(A_MODE, 16'h0003);                       // run, src 1, free running
      wr(A_CNT, 16'hFFFE);
      expect_reg("R8 load", A_CNT, 16'hFFFE);
      cyc(1);
      expect_reg("R10 at max", A_CNT, 16'hFFFF);
      cyc(1);
      expect_reg("R10 wrap", A_CNT, 16'h0000);
      expect_reg("R9 no event at wrap", A_EVT, 16'h0);
      cyc(1);
      expect_reg("R9 event after wrap", A_EVT, 16'h2);
      check("R12 irq needs enable", {15'd0, irq}, 16'h0);
      cyc(1);
      expect_reg("R10 free run past ref", A_CNT, 16'd2);
      wr(A_REF, 16'd9);
      expect_reg("R7 ref write clears counter", A_CNT, 16'd0);
   endtask

   task automatic t_prescale();
      quiesce();
      wr(A_MODE, 16'h0203);                       // P=2, src 1
      cyc(2);
      expect_reg("R4 before first step", A_CNT, 16'd0);
      cyc(3);
      expect_reg("R4 first step at 3", A_CNT, 16'd1);
      cyc(1);
      expect_reg("R4 second step at 6", A_CNT, 16'd2);
      wr(A_MODE, 16'h0005);                       // P=0, src 2
      cyc(15);
      expect_reg("R5 before 16", A_CNT, 16'd0);
      cyc(1);
      expect_reg("R5 step at 16", A_CNT, 16'd1);
      wr(A_MODE, 16'h0105);                       // P=1, src 2
      cyc(31);
      expect_reg("R5 before 32", A_CNT, 16'd0);
      cyc(1);
      expect_reg("R5 step at 32", A_CNT, 16'd1);
   endtask

   task automatic t_stopped();
      quiesce();
      wr(A_MODE, 16'h0001);                       // src 0
      cyc(10);
      expect_reg("R6 source 0 holds", A_CNT, 16'd0);
      wr(A_MODE, 16'h0007);                       // src 3
      cyc(10);
      expect_reg("R6 source 3 holds", A_CNT, 16'd0);
      wr(A_MODE, 16'h0002);                       // run clear
      wr(A_CNT, 16'h1234);
      cyc(4);
      expect_reg("R8 load while stopped", A_CNT, 16'h1234);
   endtask

   initial begin
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_regs();
      t_restart_irq();
      t_wrap();
      t_prescale();
      t_stopped();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule